// File: doc/BRIEF.md
# Prefetching Stack-Machine Bus Sequencer

This block sequences the bus accesses of a small stack-machine core whose instructions and data share one single-port memory bus. Each instruction is a 16-bit control word that names up to two inputs. An input is either an immediate word that follows in the program, or a word popped from the stack. The sequencer reads the inputs first, then fetches the next control word while the ALU works on the latched inputs. Last, it writes the result. The prefetched word is decoded during that final write, so a fetch and a decode never fall in the same cycle.

The memory is slower than the core clock. Every access is held on the bus until the ready input is high, and all state is frozen while it waits. After reset, and after a taken jump, the sequencer issues a standalone instruction fetch followed by one decode cycle. On a jump, the word prefetched by the current instruction is dropped. The ALU is outside the block; the sequencer drives its opcode and two operands and captures its result.

Top module: `stk_seq_top`

## Requirements
- R1: While reset is low and in the first cycle after it, the block requests a read (`bus_we_o`=0) of the instruction at PC_RESET, with `pc_o`=PC_RESET, `sp_o`=SP_RESET and `flag_we_o`=0.
- R2: The control word fields are: bits [1:0] select input0, bits [3:2] select input1 (0 none, 1 immediate, 2 pop, 3 none), bit 4 requests a push, bit 5 requests a flag update, and bits [15:6] go to `alu_op_o`.
- R3: The bus accesses of one instruction come in this order: the input0 read, the input1 read, the next-instruction fetch, then the result write. Unselected inputs are skipped. An immediate read and a fetch use address PC and then add 2 to PC. A pop reads at SP and then adds 2 to SP.
- R4: A push writes at SP-2, leaves SP at SP-2, and writes the ALU result that was captured at the end of the fetch cycle.
- R5: An instruction without a push spends exactly one cycle with no bus request in place of the write.
- R6: A standalone fetch is followed by exactly one cycle without a bus request (decode). After a write or idle cycle, the next instruction's first access is requested in the very next cycle.
- R7: `jump_i` is sampled in the last cycle of an instruction (the write acknowledge or the idle cycle). If it is high, the prefetched word is discarded, PC takes `jump_target_i`, and a standalone fetch at that address follows.
- R8: While a request is pending and `bus_ready_i` is low, address, write enable, write data, request, PC and SP all hold.
- R9: `flag_we_o` pulses only for instructions with the flag bit set: in the cycle the push write is acknowledged, or in the idle cycle.
- R10: An input that is not selected is presented to the ALU as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_o | output | 1 | Bus access request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | AW | Byte address of the access |
| bus_wdata_o | output | DW | Write data |
| bus_rdata_i | input | DW | Read data, valid while ready is high |
| bus_ready_i | input | 1 | Access completes at the clock edge when high with a request |
| alu_op_o | output | 10 | Function field of the current instruction |
| alu_a_o | output | DW | Latched input0 |
| alu_b_o | output | DW | Latched input1 |
| alu_res_i | input | DW | ALU result from `alu_a_o`, `alu_b_o`, `alu_op_o` |
| flag_we_o | output | 1 | Flag register update strobe |
| jump_i | input | 1 | Jump request for the current instruction |
| jump_target_i | input | AW | Jump destination |
| pc_o | output | AW | Program counter |
| sp_o | output | AW | Stack pointer |

## Verification
A wrong state in this sequencer shows up on the bus within one access. If the pointers are off, the next immediate, pop or fetch address is wrong at once. If the state ordering is wrong, the request pattern departs from the fixed input, input, fetch, write rhythm, or a decode gap goes missing, on the cycle it happens. A result captured at the wrong time or an unselected operand that is not zeroed shows up as wrong write data at the following push. The final stack memory is compared at the end, so stale pushes are caught as well.

// File: rtl/stk_seq_pkg.sv
`timescale 1ns/1ps
package stk_seq_pkg;
  localparam int CW  = 16;
  localparam int OPW = 10;

  typedef enum logic [2:0] {
    ST_BOOT, ST_DEC, ST_IN0, ST_IN1, ST_FETCH, ST_WR, ST_IDLE
  } st_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0, SRC_IMM = 2'd1, SRC_POP = 2'd2, SRC_RSV = 2'd3
  } src_e;

  typedef struct packed {
    logic [OPW-1:0] func;
    logic           flag;
    logic           push;
    src_e           in1;
    src_e           in0;
  } ctrl_t;

  function automatic logic src_used(src_e s);
    return (s == SRC_IMM) || (s == SRC_POP);
  endfunction
endpackage

// File: rtl/stk_seq_decode.sv
`timescale 1ns/1ps
module stk_seq_decode
  import stk_seq_pkg::*;
(
  input  src_e in0_i,
  input  src_e in1_i,
  output st_e  first_o
);
  always_comb begin
    if (src_used(in0_i))      first_o = ST_IN0;
    else if (src_used(in1_i)) first_o = ST_IN1;
    else                      first_o = ST_FETCH;
  end
endmodule

// File: rtl/stk_seq_ptrs.sv
`timescale 1ns/1ps
module stk_seq_ptrs #(
  parameter int             AW       = 16,
  parameter logic [AW-1:0]  PC_RESET = '0,
  parameter logic [AW-1:0]  SP_RESET = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pc_inc_i,
  input  logic          pc_load_i,
  input  logic [AW-1:0] pc_target_i,
  input  logic          sp_inc_i,
  input  logic          sp_dec_i,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] sp_o,
  output logic [AW-1:0] sp_below_o
);
  localparam logic [AW-1:0] STEP = AW'(2);

  logic [AW-1:0] pc_q, sp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pc_q <= PC_RESET;
    else if (pc_load_i) pc_q <= pc_target_i;
    else if (pc_inc_i)  pc_q <= pc_q + STEP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sp_q <= SP_RESET;
    else if (sp_inc_i) sp_q <= sp_q + STEP;
    else if (sp_dec_i) sp_q <= sp_q - STEP;
  end

  assign pc_o       = pc_q;
  assign sp_o       = sp_q;
  assign sp_below_o = sp_q - STEP;
endmodule

// File: rtl/stk_seq_regs.sv
`timescale 1ns/1ps
module stk_seq_regs
  import stk_seq_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] rdata_i,
  input  logic          pf_ld_i,
  input  logic          ir_ld_i,
  input  logic          opnd_clr_i,
  input  logic [1:0]    opnd_ld_i,
  input  logic          res_ld_i,
  input  logic [DW-1:0] res_d_i,
  output ctrl_t         pf_o,
  output ctrl_t         ir_o,
  output logic [DW-1:0] opnd_o [2],
  output logic [DW-1:0] res_o
);
  ctrl_t         pf_q, ir_q;
  logic [DW-1:0] res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pf_q <= '0;
      ir_q <= '0;
    end else begin
      if (pf_ld_i) pf_q <= ctrl_t'(rdata_i[CW-1:0]);
      if (ir_ld_i) ir_q <= pf_q;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_opnd
    logic [DW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           q <= '0;
      else if (opnd_clr_i)   q <= '0;
      else if (opnd_ld_i[g]) q <= rdata_i;
    end
    assign opnd_o[g] = q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       res_q <= '0;
    else if (res_ld_i) res_q <= res_d_i;
  end

  assign pf_o  = pf_q;
  assign ir_o  = ir_q;
  assign res_o = res_q;
endmodule

// File: rtl/stk_seq_top.sv
`timescale 1ns/1ps
module stk_seq_top
  import stk_seq_pkg::*;
#(
  parameter int            AW       = 16,
  parameter int            DW       = 16,
  parameter logic [AW-1:0] PC_RESET = '0,
  parameter logic [AW-1:0] SP_RESET = AW'(16'h0400)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  output logic           bus_req_o,
  output logic           bus_we_o,
  output logic [AW-1:0]  bus_addr_o,
  output logic [DW-1:0]  bus_wdata_o,
  input  logic [DW-1:0]  bus_rdata_i,
  input  logic           bus_ready_i,
  output logic [OPW-1:0] alu_op_o,
  output logic [DW-1:0]  alu_a_o,
  output logic [DW-1:0]  alu_b_o,
  input  logic [DW-1:0]  alu_res_i,
  output logic           flag_we_o,
  input  logic           jump_i,
  input  logic [AW-1:0]  jump_target_i,
  output logic [AW-1:0]  pc_o,
  output logic [AW-1:0]  sp_o
);
  st_e           st_q, st_d, pf_first;
  ctrl_t         pf, ir;
  logic [DW-1:0] opnd [2];
  logic [DW-1:0] res;
  logic [AW-1:0] pc, sp, sp_below;
  logic          ack, finish;
  logic          pc_inc, pc_load, sp_inc, sp_dec;
  logic          pf_ld, ir_ld, opnd_clr, res_ld;
  logic [1:0]    opnd_ld;

  stk_seq_decode u_dec (
    .in0_i   (pf.in0),
    .in1_i   (pf.in1),
    .first_o (pf_first)
  );

  stk_seq_ptrs #(.AW(AW), .PC_RESET(PC_RESET), .SP_RESET(SP_RESET)) u_ptrs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pc_inc_i    (pc_inc),
    .pc_load_i   (pc_load),
    .pc_target_i (jump_target_i),
    .sp_inc_i    (sp_inc),
    .sp_dec_i    (sp_dec),
    .pc_o        (pc),
    .sp_o        (sp),
    .sp_below_o  (sp_below)
  );

  stk_seq_regs #(.DW(DW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rdata_i    (bus_rdata_i),
    .pf_ld_i    (pf_ld),
    .ir_ld_i    (ir_ld),
    .opnd_clr_i (opnd_clr),
    .opnd_ld_i  (opnd_ld),
    .res_ld_i   (res_ld),
    .res_d_i    (alu_res_i),
    .pf_o       (pf),
    .ir_o       (ir),
    .opnd_o     (opnd),
    .res_o      (res)
  );

  assign bus_req_o = (st_q == ST_BOOT) || (st_q == ST_IN0) || (st_q == ST_IN1) ||
                     (st_q == ST_FETCH) || (st_q == ST_WR);
  assign bus_we_o  = (st_q == ST_WR);
  assign ack       = bus_req_o && bus_ready_i;

  always_comb begin
    unique case (st_q)
      ST_IN0:  bus_addr_o = (ir.in0 == SRC_IMM) ? pc : sp;
      ST_IN1:  bus_addr_o = (ir.in1 == SRC_IMM) ? pc : sp;
      ST_WR:   bus_addr_o = sp_below;
      default: bus_addr_o = pc;
    endcase
  end

  always_comb begin
    st_d     = st_q;
    pc_inc   = 1'b0;
    pc_load  = 1'b0;
    sp_inc   = 1'b0;
    sp_dec   = 1'b0;
    pf_ld    = 1'b0;
    ir_ld    = 1'b0;
    opnd_clr = 1'b0;
    opnd_ld  = 2'b00;
    res_ld   = 1'b0;
    finish   = 1'b0;
    unique case (st_q)
      ST_BOOT: if (ack) begin
        pf_ld  = 1'b1;
        pc_inc = 1'b1;
        st_d   = ST_DEC;
      end
      ST_DEC: begin
        ir_ld    = 1'b1;
        opnd_clr = 1'b1;
        st_d     = pf_first;
      end
      ST_IN0: if (ack) begin
        opnd_ld[0] = 1'b1;
        pc_inc     = (ir.in0 == SRC_IMM);
        sp_inc     = (ir.in0 == SRC_POP);
        st_d       = src_used(ir.in1) ? ST_IN1 : ST_FETCH;
      end
      ST_IN1: if (ack) begin
        opnd_ld[1] = 1'b1;
        pc_inc     = (ir.in1 == SRC_IMM);
        sp_inc     = (ir.in1 == SRC_POP);
        st_d       = ST_FETCH;
      end
      ST_FETCH: if (ack) begin
        pf_ld  = 1'b1;
        pc_inc = 1'b1;
        res_ld = 1'b1;
        st_d   = ir.push ? ST_WR : ST_IDLE;
      end
      ST_WR: if (ack) begin
        sp_dec = 1'b1;
        finish = 1'b1;
      end
      default: finish = 1'b1;
    endcase
    // end of instruction: redirect, or start the word decoded this cycle
    if (finish) begin
      if (jump_i) begin
        pc_load = 1'b1;
        st_d    = ST_BOOT;
      end else begin
        ir_ld    = 1'b1;
        opnd_clr = 1'b1;
        st_d     = pf_first;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_BOOT;
    else         st_q <= st_d;
  end

  assign bus_wdata_o = res;
  assign alu_op_o    = ir.func;
  assign alu_a_o     = opnd[0];
  assign alu_b_o     = opnd[1];
  assign flag_we_o   = ir.flag && (((st_q == ST_WR) && bus_ready_i) || (st_q == ST_IDLE));
  assign pc_o        = pc;
  assign sp_o        = sp;
endmodule

// File: rtl/stk_seq_chk.sv
`timescale 1ns/1ps
module stk_seq_chk #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bus_req_o,
  input logic          bus_we_o,
  input logic          bus_ready_i,
  input logic [AW-1:0] bus_addr_o,
  input logic [DW-1:0] bus_wdata_o,
  input logic          flag_we_o,
  input logic [AW-1:0] pc_o,
  input logic [AW-1:0] sp_o
);
  localparam logic [AW-1:0] STEP = AW'(2);

  // R8
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ready_i |=> bus_req_o && $stable(bus_addr_o) &&
                                  $stable(bus_we_o) && $stable(bus_wdata_o));

  // R8
  ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ready_i |=> $stable(pc_o) && $stable(sp_o));

  // R4
  push_sp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_ready_i && bus_we_o |=> sp_o == $past(bus_addr_o));

  // R3
  read_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_ready_i && !bus_we_o |=>
      (pc_o == $past(bus_addr_o) + STEP) || (sp_o == $past(bus_addr_o) + STEP));

  // R9
  flag_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_o |-> !bus_req_o || (bus_we_o && bus_ready_i));
endmodule

bind stk_seq_top stk_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_req_o   (bus_req_o),
  .bus_we_o    (bus_we_o),
  .bus_ready_i (bus_ready_i),
  .bus_addr_o  (bus_addr_o),
  .bus_wdata_o (bus_wdata_o),
  .flag_we_o   (flag_we_o),
  .pc_o        (pc_o),
  .sp_o        (sp_o)
);

// File: tb/sim_stk_seq_top.sv
`timescale 1ns/1ps
module sim_stk_seq_top;
  localparam int AW  = 16;
  localparam int DW  = 16;
  localparam int LIM = 60;

  logic           clk = 1'b0;
  logic           rst_ni;
  logic           bus_req_o, bus_we_o, bus_ready_i, flag_we_o, jump_i;
  logic [AW-1:0]  bus_addr_o, jump_target_i, pc_o, sp_o;
  logic [DW-1:0]  bus_wdata_o, bus_rdata_i, alu_a_o, alu_b_o, alu_res_i;
  logic [9:0]     alu_op_o;

  logic [DW-1:0]  mem [512];
  logic [DW-1:0]  rm  [512];
  logic [AW-1:0]  log_addr [LIM];
  logic           log_we   [LIM];
  logic [DW-1:0]  log_data [LIM];
  logic [AW-1:0]  exp_addr [LIM];
  logic           exp_we   [LIM];
  logic [DW-1:0]  exp_data [LIM];
  int             exp_n, got, mode, checks, fails;
  logic [AW-1:0]  jmp_tgt;

  always #4 clk = ~clk;

  function automatic logic [15:0] alu_f(logic [9:0] op, logic [15:0] a, logic [15:0] b);
    case (op)
      10'd0:   return a + b;
      10'd1:   return a - b;
      10'd2:   return a ^ b;
      default: return a;
    endcase
  endfunction

  assign bus_rdata_i   = mem[bus_addr_o[9:1]];
  assign alu_res_i     = alu_f(alu_op_o, alu_a_o, alu_b_o);
  assign jump_i        = (alu_op_o == 10'h00F);
  assign jump_target_i = jmp_tgt;

  stk_seq_top u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
    .bus_wdata_o(bus_wdata_o), .bus_rdata_i(bus_rdata_i), .bus_ready_i(bus_ready_i),
    .alu_op_o(alu_op_o), .alu_a_o(alu_a_o), .alu_b_o(alu_b_o), .alu_res_i(alu_res_i),
    .flag_we_o(flag_we_o), .jump_i(jump_i), .jump_target_i(jump_target_i),
    .pc_o(pc_o), .sp_o(sp_o)
  );

  // bus slave: ready decided at the falling edge, access completes at the next rising edge
  initial begin
    bus_ready_i = 1'b0;
    forever begin
      @(negedge clk);
      case (mode)
        1:       bus_ready_i = (got < LIM);
        2:       bus_ready_i = (got < LIM) && ($urandom_range(0, 3) == 0);
        default: bus_ready_i = 1'b0;
      endcase
      if (rst_ni && bus_req_o && bus_ready_i) begin
        log_addr[got] = bus_addr_o;
        log_we[got]   = bus_we_o;
        log_data[got] = bus_we_o ? bus_wdata_o : bus_rdata_i;
        if (bus_we_o) mem[bus_addr_o[9:1]] = bus_wdata_o;
        got++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic load_prog();
    for (int i = 0; i < 512; i++) mem[i] = '0;
    mem[0] = 16'h0015; mem[1] = 16'h0005; mem[2] = 16'h0007;
    mem[3] = 16'h0036; mem[4] = 16'h0100;
    mem[5] = 16'h0051; mem[6] = 16'h0003;
    mem[7] = 16'h009A;
    mem[8] = 16'h00E2;
    mem[9] = 16'h03C0;
    jmp_tgt = '0;
  endtask

  task automatic emit(input logic [15:0] a, input logic w, input logic [15:0] d);
    if (exp_n < LIM) begin
      exp_addr[exp_n] = a;
      exp_we[exp_n]   = w;
      exp_data[exp_n] = d;
      if (w) rm[a[9:1]] = d;
      exp_n++;
    end
  endtask

  // behavioural program/stack model built from the requirements
  task automatic ref_run();
    logic [15:0] pc, sp, ir, pf, a, b, res, v;
    bit brk;
    for (int i = 0; i < 512; i++) rm[i] = mem[i];
    exp_n = 0;
    pc = 16'h0000;
    sp = 16'h0400;
    while (exp_n < LIM) begin
      ir = rm[pc[9:1]];
      emit(pc, 1'b0, ir);
      pc += 16'd2;
      brk = 1'b0;
      while (!brk && exp_n < LIM) begin
        a = '0;
        b = '0;
        for (int k = 0; k < 2; k++) begin
          logic [1:0] s;
          s = (k == 0) ? ir[1:0] : ir[3:2];
          v = '0;
          if (s == 2'd1) begin
            v = rm[pc[9:1]]; emit(pc, 1'b0, v); pc += 16'd2;
          end else if (s == 2'd2) begin
            v = rm[sp[9:1]]; emit(sp, 1'b0, v); sp += 16'd2;
          end
          if (k == 0) a = v; else b = v;
        end
        pf = rm[pc[9:1]];
        emit(pc, 1'b0, pf);
        pc += 16'd2;
        res = alu_f(ir[15:6], a, b);
        if (ir[4]) begin
          sp -= 16'd2;
          emit(sp, 1'b1, res);
        end
        if (ir[15:6] == 10'h00F) begin
          pc  = jmp_tgt;
          brk = 1'b1;
        end else begin
          ir = pf;
        end
      end
    end
  endtask

  task automatic start(input int m);
    rst_ni = 1'b0;
    mode   = 0;
    repeat (2) @(negedge clk);
    got  = 0;
    mode = m;
    @(posedge clk);
    #2 rst_ni = 1'b1;
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    mode   = 0;
    load_prog();
    repeat (2) @(negedge clk);
    #1;
    chk(bus_req_o == 1'b1, "R1", "req in reset", 32'(bus_req_o), 32'd1);
    chk(bus_we_o == 1'b0, "R1", "we in reset", 32'(bus_we_o), 32'd0);
    chk(bus_addr_o == 16'h0000, "R1", "addr in reset", 32'(bus_addr_o), 32'd0);
    chk(pc_o == 16'h0000, "R1", "pc in reset", 32'(pc_o), 32'd0);
    chk(sp_o == 16'h0400, "R1", "sp in reset", 32'(sp_o), 32'h400);
    chk(flag_we_o == 1'b0, "R1", "flag in reset", 32'(flag_we_o), 32'd0);
  endtask

  task automatic t_stall();
    load_prog();
    start(0);
    for (int c = 0; c < 5; c++) begin
      @(negedge clk); #1;
      chk(bus_req_o && !bus_we_o, "R8", "req held", 32'({bus_req_o, bus_we_o}), 32'h2);
      chk(bus_addr_o == 16'h0000, "R8", "addr held", 32'(bus_addr_o), 32'd0);
      chk(pc_o == 16'h0000, "R1 R8", "pc held", 32'(pc_o), 32'd0);
    end
  endtask

  // {req, we, flag, addr} per cycle with ready always high
  function automatic logic [18:0] exp_cyc(int c);
    case (c)
      0:  return {3'b100, 16'h0000};
      1:  return {3'b000, 16'h0000};
      2:  return {3'b100, 16'h0002};
      3:  return {3'b100, 16'h0004};
      4:  return {3'b100, 16'h0006};
      5:  return {3'b110, 16'h03FE};
      6:  return {3'b100, 16'h03FE};
      7:  return {3'b100, 16'h0008};
      8:  return {3'b100, 16'h000A};
      9:  return {3'b111, 16'h03FE};
      10: return {3'b100, 16'h000C};
      11: return {3'b100, 16'h000E};
      12: return {3'b110, 16'h03FC};
      13: return {3'b100, 16'h03FC};
      14: return {3'b100, 16'h03FE};
      15: return {3'b100, 16'h0010};
      16: return {3'b110, 16'h03FE};
      17: return {3'b100, 16'h03FE};
      18: return {3'b100, 16'h0012};
      19: return {3'b001, 16'h0000};
      20: return {3'b100, 16'h0014};
      21: return {3'b000, 16'h0000};
      22: return {3'b100, 16'h0000};
      23: return {3'b000, 16'h0000};
      default: return {3'b100, 16'h0002};
    endcase
  endfunction

  task automatic t_order();
    load_prog();
    start(1);
    @(negedge clk);
    for (int c = 0; c < 25; c++) begin
      logic [18:0] e;
      string tag;
      #1;
      e = exp_cyc(c);
      tag = (c == 1 || c == 23) ? "R6" : (c == 19) ? "R5 R9" :
            (c >= 20 && c <= 22) ? "R7" : (c == 9) ? "R9" : "R3 R6";
      chk({bus_req_o, bus_req_o & bus_we_o, flag_we_o} == e[18:16], tag,
          $sformatf("cycle %0d req/we/flag", c),
          32'({bus_req_o, bus_req_o & bus_we_o, flag_we_o}), 32'(e[18:16]));
      if (e[18])
        chk(bus_addr_o == e[15:0], tag, $sformatf("cycle %0d addr", c),
            32'(bus_addr_o), 32'(e[15:0]));
      if (c == 5)
        chk(bus_wdata_o == 16'h000C, "R4", "first push data", 32'(bus_wdata_o), 32'hC);
      @(negedge clk);
    end
  endtask

  task automatic t_run(input int m);
    string nm;
    nm = (m == 2) ? "random ready" : "ready high";
    load_prog();
    ref_run();
    start(m);
    while (got < LIM) @(negedge clk);
    repeat (4) @(negedge clk);
    for (int i = 0; i < LIM; i++) begin
      chk(log_addr[i] == exp_addr[i], "R2 R3", $sformatf("%s access %0d addr", nm, i),
          32'(log_addr[i]), 32'(exp_addr[i]));
      chk(log_we[i] == exp_we[i], "R3 R5", $sformatf("%s access %0d we", nm, i),
          32'(log_we[i]), 32'(exp_we[i]));
      chk(log_data[i] == exp_data[i], "R4 R10", $sformatf("%s access %0d data", nm, i),
          32'(log_data[i]), 32'(exp_data[i]));
    end
    begin
      int bad;
      bad = 0;
      for (int i = 0; i < 512; i++) if (mem[i] !== rm[i]) bad++;
      chk(bad == 0, "R4 R7", {nm, " final memory mismatching words"}, 32'(bad), 32'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    checks = 0;
    fails  = 0;
    got    = 0;
    mode   = 0;
    rst_ni = 1'b0;
    t_reset();
    t_stall();
    t_order();
    t_run(1);
    t_run(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule